// File: doc/BRIEF.md
# Register Result Status Rename Table

This block keeps one status entry and one value entry for each register of a small floating-point register file. The status entry holds the tag of the reservation station that will produce the register's next value. Tag 0 is reserved and means that no producer is pending, so the value entry is current. Each cycle the table answers two issue-time lookups. For each source register it returns either the value together with tag 0, or the nonzero tag of the pending producer. When an instruction issues, the table records the issuing station's tag against the destination register.

The table also watches the result broadcast bus. A broadcast result is written into a register only while that register still names the broadcasting tag. If a younger instruction has since claimed the register, the older result is dropped for that register. This makes write-after-write ordering safe without a stall.

Both input streams carry a valid qualifier and no ready signal. The table accepts an issue and a broadcast in every cycle, so it never applies back-pressure. The lookups are combinational and always reflect the source indices on the issue port, whether or not `iss_valid` is high.

Top module: `rename_table`

## Requirements
- R1: When a source register's status is 0 and no broadcast forwards to it, the lookup returns that register's stored value with tag 0.
- R2: When a source register's status is nonzero and no broadcast that cycle names that tag, the lookup returns that tag with a data field of 0.
- R3: An issue with a nonzero tag overwrites the destination's status with that tag from the next cycle on, even when an earlier producer is still pending.
- R4: A valid broadcast with nonzero tag t writes its data into every register whose status equals t and clears each such status to 0 in the next cycle.
- R5: A register whose status differs from the broadcast tag keeps its value and its status; an older result reaching a register that a younger tag has claimed is lost.
- R6: A source index equal to the destination of the same issue sees the status from before that issue.
- R7: A lookup whose status equals the tag being broadcast in that same cycle returns the broadcast data with tag 0.
- R8: When an issue claims a register in the same cycle that a broadcast would clear it, the register ends up holding the issue's tag.
- R9: After reset, every status is 0 and every stored value is 0.
- R10: An issue with tag 0 and a broadcast with tag 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An issue is presented this cycle |
| iss_src_a | input | IDX_W | First source register index |
| iss_src_b | input | IDX_W | Second source register index |
| iss_dst | input | IDX_W | Destination register index |
| iss_tag | input | TAG_W | Tag of the issuing station (nonzero) |
| cdb_valid | input | 1 | A result is broadcast this cycle |
| cdb_tag | input | TAG_W | Tag of the broadcasting station |
| cdb_data | input | DATA_W | Broadcast result value |
| opa_tag | output | TAG_W | First operand: pending tag, or 0 when the data is valid |
| opa_data | output | DATA_W | First operand value (0 while a tag is pending) |
| opb_tag | output | TAG_W | Second operand: pending tag, or 0 when the data is valid |
| opb_data | output | DATA_W | Second operand value (0 while a tag is pending) |

## Verification
A status entry holding the wrong tag shows up on the very next lookup of that register. It appears either as a wrong pending tag, or as a value reported ready too early. A broadcast that is wrongly accepted or wrongly dropped leaves behind a corrupted value or a tag that never clears. That damage becomes visible one cycle after the broadcast, the first time the register is looked up. Because the lookup ports read the table directly, sweeping every index through them after each stimulus exposes any divergent entry within one cycle.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int unsigned NREG_DEF   = 16;
  localparam int unsigned TAG_W_DEF  = 4;
  localparam int unsigned DATA_W_DEF = 32;

  typedef enum logic [1:0] {
    OPND_FILE    = 2'd0,
    OPND_FORWARD = 2'd1,
    OPND_PENDING = 2'd2
  } opnd_src_e;
endpackage

// File: rtl/rt_status_array.sv
module rt_status_array #(
  parameter int unsigned NREG  = rt_pkg::NREG_DEF,
  parameter int unsigned TAG_W = rt_pkg::TAG_W_DEF,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        iss_valid,
  input  logic [IDX_W-1:0]            iss_dst,
  input  logic [TAG_W-1:0]            iss_tag,
  input  logic                        cdb_valid,
  input  logic [TAG_W-1:0]            cdb_tag,
  output logic [NREG-1:0][TAG_W-1:0]  stat_q
);
  logic claim_ok;
  logic bcast_ok;

  assign claim_ok = iss_valid && (iss_tag != '0);
  assign bcast_ok = cdb_valid && (cdb_tag != '0);

  for (genvar i = 0; i < NREG; i++) begin : g_entry
    logic claim_i;
    logic clear_i;

    assign claim_i = claim_ok && (iss_dst == IDX_W'(i));
    assign clear_i = bcast_ok && (stat_q[i] == cdb_tag);

    always_ff @(posedge clk) begin
      if (!rst_n)       stat_q[i] <= '0;
      else if (claim_i) stat_q[i] <= iss_tag;
      else if (clear_i) stat_q[i] <= '0;
    end

    // R3 and R8: an issue claim wins over a broadcast clear
    p_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_tag != '0 && iss_dst == IDX_W'(i)) |=> stat_q[i] == $past(iss_tag));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && cdb_tag != '0 && stat_q[i] == cdb_tag &&
       !(iss_valid && iss_tag != '0 && iss_dst == IDX_W'(i))) |=> stat_q[i] == '0);

    p_other_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cdb_valid && cdb_tag != '0 && stat_q[i] == cdb_tag) &&
       !(iss_valid && iss_tag != '0 && iss_dst == IDX_W'(i))) |=> $stable(stat_q[i]));
  end
endmodule

// File: rtl/rt_value_file.sv
module rt_value_file #(
  parameter int unsigned NREG   = rt_pkg::NREG_DEF,
  parameter int unsigned TAG_W  = rt_pkg::TAG_W_DEF,
  parameter int unsigned DATA_W = rt_pkg::DATA_W_DEF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NREG-1:0][TAG_W-1:0]  stat_q,
  input  logic                        cdb_valid,
  input  logic [TAG_W-1:0]            cdb_tag,
  input  logic [DATA_W-1:0]           cdb_data,
  output logic [NREG-1:0][DATA_W-1:0] val_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_entry
    logic wr_i;
    assign wr_i = cdb_valid && (cdb_tag != '0) && (stat_q[i] == cdb_tag);

    always_ff @(posedge clk) begin
      if (!rst_n)    val_q[i] <= '0;
      else if (wr_i) val_q[i] <= cdb_data;
    end

    p_val_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(cdb_valid && cdb_tag != '0 && stat_q[i] == cdb_tag) |=> $stable(val_q[i]));

    p_val_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && cdb_tag != '0 && stat_q[i] == cdb_tag) |=> val_q[i] == $past(cdb_data));
  end
endmodule

// File: rtl/rt_lookup.sv
module rt_lookup #(
  parameter int unsigned NREG   = rt_pkg::NREG_DEF,
  parameter int unsigned TAG_W  = rt_pkg::TAG_W_DEF,
  parameter int unsigned DATA_W = rt_pkg::DATA_W_DEF,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            idx,
  input  logic [NREG-1:0][TAG_W-1:0]  stat_q,
  input  logic [NREG-1:0][DATA_W-1:0] val_q,
  input  logic                        cdb_valid,
  input  logic [TAG_W-1:0]            cdb_tag,
  input  logic [DATA_W-1:0]           cdb_data,
  output logic [TAG_W-1:0]            out_tag,
  output logic [DATA_W-1:0]           out_data
);
  import rt_pkg::*;

  logic [TAG_W-1:0] st;
  opnd_src_e        kind;

  assign st = stat_q[idx];

  always_comb begin
    if (st == '0)                                         kind = OPND_FILE;
    else if (cdb_valid && cdb_tag != '0 && st == cdb_tag) kind = OPND_FORWARD;
    else                                                  kind = OPND_PENDING;
  end

  always_comb begin
    unique case (kind)
      OPND_FILE:    begin out_tag = '0; out_data = val_q[idx]; end
      OPND_FORWARD: begin out_tag = '0; out_data = cdb_data;   end
      default:      begin out_tag = st; out_data = '0;         end
    endcase
  end

  // R7: a tag on the bus this cycle is never reported as still pending
  p_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && cdb_tag != '0) |-> out_tag != cdb_tag);

  p_pending_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tag != '0) |-> out_data == '0);
endmodule

// File: rtl/rename_table.sv
module rename_table #(
  parameter int unsigned NREG   = rt_pkg::NREG_DEF,
  parameter int unsigned TAG_W  = rt_pkg::TAG_W_DEF,
  parameter int unsigned DATA_W = rt_pkg::DATA_W_DEF,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [IDX_W-1:0]  iss_src_a,
  input  logic [IDX_W-1:0]  iss_src_b,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic [TAG_W-1:0]  opa_tag,
  output logic [DATA_W-1:0] opa_data,
  output logic [TAG_W-1:0]  opb_tag,
  output logic [DATA_W-1:0] opb_data
);
  localparam int unsigned NPORT = 2;

  logic [NREG-1:0][TAG_W-1:0]  stat_q;
  logic [NREG-1:0][DATA_W-1:0] val_q;
  logic [NPORT-1:0][IDX_W-1:0]  port_idx;
  logic [NPORT-1:0][TAG_W-1:0]  port_tag;
  logic [NPORT-1:0][DATA_W-1:0] port_data;

  rt_status_array #(.NREG(NREG), .TAG_W(TAG_W)) u_status (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
    .iss_tag(iss_tag), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .stat_q(stat_q)
  );

  rt_value_file #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_values (
    .clk(clk), .rst_n(rst_n), .stat_q(stat_q), .cdb_valid(cdb_valid),
    .cdb_tag(cdb_tag), .cdb_data(cdb_data), .val_q(val_q)
  );

  assign port_idx[0] = iss_src_a;
  assign port_idx[1] = iss_src_b;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    rt_lookup #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lookup (
      .clk(clk), .rst_n(rst_n), .idx(port_idx[p]), .stat_q(stat_q), .val_q(val_q),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .out_tag(port_tag[p]), .out_data(port_data[p])
    );
  end

  assign opa_tag  = port_tag[0];
  assign opa_data = port_data[0];
  assign opb_tag  = port_tag[1];
  assign opb_data = port_data[1];

  // R6: a lookup of the destination being claimed shows the older status
  p_self_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_tag != '0 && iss_src_a == iss_dst && !cdb_valid &&
     opa_tag != iss_tag) |-> opa_tag == stat_q[iss_dst]);
endmodule

// File: tb/test_rename_table.sv
module test_rename_table;
  localparam int NREG = 16;
  localparam int TW = 4;
  localparam int DW = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic iss_valid = 0;
  logic [3:0] iss_src_a = 0, iss_src_b = 0, iss_dst = 0;
  logic [TW-1:0] iss_tag = 0;
  logic cdb_valid = 0;
  logic [TW-1:0] cdb_tag = 0;
  logic [DW-1:0] cdb_data = 0;
  logic [TW-1:0] opa_tag, opb_tag;
  logic [DW-1:0] opa_data, opb_data;

  int n_run = 0;
  int n_fail = 0;
  logic [TW-1:0] ms [NREG];
  logic [DW-1:0] mv [NREG];

  always #2.5 clk = ~clk;

  rename_table i_rename_table (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_src_a(iss_src_a),
    .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .opa_tag(opa_tag), .opa_data(opa_data), .opb_tag(opb_tag), .opb_data(opb_data)
  );

  function automatic logic [TW+DW-1:0] expect_op(input int idx);
    if (ms[idx] == 0) return {TW'(0), mv[idx]};
    if (cdb_valid && cdb_tag != 0 && ms[idx] == cdb_tag) return {TW'(0), cdb_data};
    return {ms[idx], DW'(0)};
  endfunction

  task automatic check_ports(input string req);
    logic [TW+DW-1:0] ea, eb;
    ea = expect_op(int'(iss_src_a));
    eb = expect_op(int'(iss_src_b));
    n_run++;
    if ({opa_tag, opa_data} !== ea || {opb_tag, opb_data} !== eb) begin
      n_fail++;
      $display("FAIL %s: a=%h/%h b=%h/%h expected a=%h/%h b=%h/%h", req,
               opa_tag, opa_data, opb_tag, opb_data,
               ea[TW+DW-1:DW], ea[DW-1:0], eb[TW+DW-1:DW], eb[DW-1:0]);
    end
  endtask

  task automatic model_update();
    for (int i = 0; i < NREG; i++) begin
      logic hit;
      hit = cdb_valid && cdb_tag != 0 && ms[i] == cdb_tag;
      if (hit) mv[i] = cdb_data;
      if (iss_valid && iss_tag != 0 && int'(iss_dst) == i) ms[i] = iss_tag;
      else if (hit) ms[i] = 0;
    end
  endtask

  task automatic step(input logic iv, input int sa, input int sb, input int d,
                      input int t, input logic cv, input int ct, input logic [DW-1:0] cd,
                      input string req);
    @(negedge clk);
    iss_valid = iv; iss_src_a = 4'(sa); iss_src_b = 4'(sb); iss_dst = 4'(d);
    iss_tag = TW'(t); cdb_valid = cv; cdb_tag = TW'(ct); cdb_data = cd;
    #1 check_ports(req);
    @(posedge clk);
    model_update();
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < NREG; i += 2) step(0, i, i + 1, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin ms[i] = 0; mv[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    sweep("R9 reset state");
    // R2 and R3: claim and reclaim while pending
    step(1, 0, 0, 5, 3, 0, 0, 0, "R3 first claim");
    step(0, 5, 5, 0, 0, 0, 0, 0, "R2 pending tag");
    step(1, 5, 0, 5, 7, 0, 0, 0, "R6 self source");
    step(0, 5, 4, 0, 0, 0, 0, 0, "R3 reclaim");
    // R5: the older producer's result is dropped
    step(0, 5, 6, 0, 0, 1, 3, 32'hDEAD0003, "R5 stale broadcast");
    step(0, 5, 5, 0, 0, 1, 7, 32'hCAFE0007, "R7 forward");
    step(0, 5, 6, 0, 0, 0, 0, 0, "R1 value after write");
    // R4: one broadcast fills two registers
    step(1, 0, 0, 1, 2, 0, 0, 0, "R4 claim r1");
    step(1, 0, 0, 2, 2, 0, 0, 0, "R4 claim r2");
    step(0, 1, 2, 0, 0, 1, 2, 32'h12345678, "R4 broadcast");
    step(0, 1, 2, 0, 0, 0, 0, 0, "R4 both written");
    // R8: claim beats clear
    step(1, 0, 0, 9, 4, 0, 0, 0, "R8 setup");
    step(1, 9, 9, 9, 6, 1, 4, 32'h44, "R8 same cycle");
    step(0, 9, 9, 0, 0, 0, 0, 0, "R8 tag kept");
    // R10: zero tags are inert
    step(1, 0, 0, 10, 0, 0, 0, 0, "R10 zero issue");
    step(0, 10, 0, 0, 0, 1, 0, 32'hFFFF, "R10 zero broadcast");
    sweep("R10 table intact");
    // random traffic, broadcasts aimed at live tags
    for (int k = 0; k < 4000; k++) begin
      int r, ct;
      r = $urandom_range(0, NREG - 1);
      ct = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : int'(ms[r]);
      step($urandom_range(0, 1) == 1, $urandom_range(0, 15), $urandom_range(0, 15),
           $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 2) != 0,
           ct, $urandom, "R1 R2 R4 R5 R7 random");
    end
    sweep("R4 R5 final sweep");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule